// File: doc/BRIEF.md
# Satellite Control Tone Envelope Transmitter

This block produces the on/off keying envelope for a 22 kHz tone source that talks to satellite dish equipment such as switches and positioners. The tone is on whenever the envelope is high. A host loads a message into a small byte store, one byte per cycle, picks an operation on the mode input and pulses start. The block then plays out the whole frame by itself and signals completion.

Each bit occupies three equal sub-slots. A one keeps the envelope high for the first sub-slot and low for the other two. A zero keeps it high for two sub-slots and low for the last one. Every byte goes out most significant bit first and carries a trailing odd-parity bit. A frame opens and closes with a fixed quiet gap. A frame may also end with a burst: either an unbroken stretch of tone, or the byte 0xFF with normal coding. A longer quiet guard follows any burst. All durations are whole counts of a microsecond tick, which is divided down from the system clock.

Top module: `tone_envelope_tx`

## Requirements
- R1: After synchronous reset `env`, `busy` and `done` are all low, and the block waits for a start.
- R2: A one bit is T_SHORT_US ticks high then T_LONG_US ticks low. A zero bit is T_LONG_US ticks high then T_SHORT_US ticks low.
- R3: The eight data bits of a byte go out with bit 7 first. A ninth bit follows, equal to 1 XOR all eight data bits.
- R4: In message mode the envelope stays low for T_GAP_US ticks, then carries the stored bytes in load order, then stays low for another T_GAP_US ticks. The frame then ends with no burst and no guard.
- R5: In tone-burst mode no stored byte is sent. The frame is: low for T_GAP_US, low for T_GAP_US, high for T_BURST_US, then low for T_GUARD_US.
- R6: In modulated-burst mode no stored byte is sent. The frame is: low for T_GAP_US, low for T_GAP_US, the byte 0xFF coded as in R2 and R3, then low for T_GUARD_US.
- R7: `mode` encoding: 0 message, 1 tone burst, 2 modulated burst, 3 message (same as 0).
- R8: A byte on `ldData` with `ldValid` high is stored only while idle and only while fewer than MAX_BYTES are held. Further bytes are dropped. An accepted start empties the store. A message with no stored bytes is just the two quiet gaps.
- R9: While `busy` is high, `start` and `ldValid` are ignored. The frame in progress is unchanged, and nothing is added to the next message.
- R10: `done` is high for exactly one cycle: the first cycle in which `busy` is low after a frame. `busy` is high from the cycle after start is accepted until then.
- R11: A duration of D ticks lasts exactly D × CLK_PER_US clock cycles. The first quiet gap begins at the clock edge that accepts start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ldValid | input | 1 | Byte load strobe |
| ldData | input | 8 | Byte to append to the message store |
| start | input | 1 | Start a frame (honoured only while idle) |
| mode | input | 2 | Operation select, see R7 |
| env | output | 1 | Tone envelope, high means tone on |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at frame end |

## Verification
A wrong bit pointer or parity register shows up as a high pulse of the wrong length within a single bit period (three sub-slots). A wrong byte index or stored count shows up as extra or missing bit cells before the closing gap. A miscounted prescaler or timer stretches or shrinks every run of the envelope, beginning with the opening gap. Mode or burst sequencing faults change the shape of the frame after the closing gap, or move the cycle in which `done` rises.

// File: rtl/tone_env_pkg.sv
package tone_env_pkg;

  typedef enum logic [1:0] {
    MODE_MSG  = 2'd0,
    MODE_TONE = 2'd1,
    MODE_DATA = 2'd2,
    MODE_MSG2 = 2'd3
  } modeE;

  typedef enum logic [2:0] {
    SEG_GAP,
    SEG_BIT_HI,
    SEG_BIT_LO,
    SEG_BURST,
    SEG_GUARD
  } segE;

  // strobes from control to datapath
  typedef struct packed {
    logic armSeg;   // load segment timer
    segE  segKind;  // which duration to load
    logic loadMsg;  // frame start: latch length, first byte, clear prescaler
    logic stepBit;  // advance to next bit (or next byte after parity)
  } ctlS;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/tone_env_datapath.sv
module tone_env_datapath
  import tone_env_pkg::*;
#(
  parameter int CLK_PER_US  = 100,
  parameter int MAX_BYTES   = 8,
  parameter int T_SHORT_US  = 500,
  parameter int T_LONG_US   = 1000,
  parameter int T_GAP_US    = 16000,
  parameter int T_BURST_US  = 12500,
  parameter int T_GUARD_US  = 20000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       busy,
  input  ctlS        ctl,
  input  modeE       mode,
  input  logic       ldValid,
  input  logic [7:0] ldData,
  output logic       segEnd,
  output logic       curBit,
  output logic       bitWrap,
  output logic       allSent,
  output logic       hasBytes
);

  localparam int MAXD    = maxOf(maxOf(T_GAP_US, T_GUARD_US), maxOf(T_BURST_US, T_LONG_US));
  localparam int TMR_W   = $clog2(MAXD + 1);
  localparam int PRESC_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam int IDX_W   = $clog2(MAX_BYTES + 1);
  localparam int ADDR_W  = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;

  // ---------------- microsecond tick ----------------
  logic [PRESC_W-1:0] presc;
  logic               tick;
  assign tick = (presc == PRESC_W'(CLK_PER_US - 1));

  always_ff @(posedge clk) begin
    if (rst || ctl.loadMsg) presc <= '0;
    else if (busy)          presc <= tick ? '0 : presc + PRESC_W'(1);
  end

  // ---------------- segment timer ----------------
  logic [TMR_W-1:0] tmr, dur;

  always_comb begin
    case (ctl.segKind)
      SEG_BIT_HI: dur = curBit ? TMR_W'(T_SHORT_US) : TMR_W'(T_LONG_US);
      SEG_BIT_LO: dur = curBit ? TMR_W'(T_LONG_US)  : TMR_W'(T_SHORT_US);
      SEG_BURST:  dur = TMR_W'(T_BURST_US);
      SEG_GUARD:  dur = TMR_W'(T_GUARD_US);
      default:    dur = TMR_W'(T_GAP_US);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                     tmr <= '0;
    else if (ctl.armSeg)         tmr <= dur;
    else if (tick && tmr != '0)  tmr <= tmr - TMR_W'(1);
  end

  assign segEnd = busy && tick && (tmr == TMR_W'(1));

  // ---------------- message store ----------------
  logic [7:0]       msgMem [MAX_BYTES];
  logic [IDX_W-1:0] wrCnt, byteIdx, msgLen, nextIdx;
  logic             ldOk;

  assign ldOk = ldValid && !busy && !ctl.loadMsg && (wrCnt < IDX_W'(MAX_BYTES));

  always_ff @(posedge clk) begin
    if (rst || ctl.loadMsg) wrCnt <= '0;
    else if (ldOk)          wrCnt <= wrCnt + IDX_W'(1);
  end

  always_ff @(posedge clk) begin
    if (ldOk) msgMem[wrCnt[ADDR_W-1:0]] <= ldData;
  end

  // ---------------- bit serializer ----------------
  logic [7:0] shreg, nextByte;
  logic       par;
  logic [3:0] bitIdx;

  assign nextIdx  = byteIdx + IDX_W'(1);
  assign nextByte = (nextIdx < msgLen) ? msgMem[nextIdx[ADDR_W-1:0]] : 8'h00;
  assign curBit   = (bitIdx == 4'd8) ? par : shreg[7];
  assign bitWrap  = (bitIdx == 4'd0);
  assign allSent  = (byteIdx == msgLen);
  assign hasBytes = (msgLen != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0; par <= 1'b1; bitIdx <= '0; byteIdx <= '0; msgLen <= '0;
    end else if (ctl.loadMsg) begin
      par     <= 1'b1;
      bitIdx  <= '0;
      byteIdx <= '0;
      if (mode == MODE_DATA) begin
        shreg  <= 8'hFF;
        msgLen <= IDX_W'(1);
      end else if (mode == MODE_TONE) begin
        shreg  <= 8'h00;
        msgLen <= '0;
      end else begin
        shreg  <= msgMem[0];
        msgLen <= wrCnt;
      end
    end else if (ctl.stepBit) begin
      if (bitIdx == 4'd8) begin
        bitIdx  <= '0;
        par     <= 1'b1;
        byteIdx <= nextIdx;
        shreg   <= nextByte;
      end else begin
        par    <= par ^ shreg[7];
        shreg  <= {shreg[6:0], 1'b0};
        bitIdx <= bitIdx + 4'd1;
      end
    end
  end

  // ---------------- assertions ----------------
  a_r3_bit_index_range: assert property (@(posedge clk) disable iff (rst)
    bitIdx <= 4'd8);

  a_r8_count_bound: assert property (@(posedge clk) disable iff (rst)
    wrCnt <= IDX_W'(MAX_BYTES));

  a_r9_len_stable_busy: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(msgLen));

  a_r11_seg_nonzero: assert property (@(posedge clk) disable iff (rst)
    ctl.armSeg |-> (dur != '0));

endmodule

// File: rtl/tone_env_ctrl.sv
module tone_env_ctrl
  import tone_env_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  modeE mode,
  input  logic segEnd,
  input  logic bitWrap,
  input  logic allSent,
  input  logic hasBytes,
  output ctlS  ctl,
  output logic env,
  output logic busy,
  output logic done
);

  typedef enum logic [2:0] {
    S_IDLE, S_LEAD, S_BHI, S_BLO, S_TAIL, S_TONE, S_GUARD
  } stateE;

  stateE state, nxt;
  modeE  modeQ;
  logic  fin, isMsg;

  assign isMsg = (modeQ == MODE_MSG) || (modeQ == MODE_MSG2);

  always_comb begin
    ctl         = '0;
    ctl.segKind = SEG_GAP;
    nxt         = state;
    fin         = 1'b0;
    case (state)
      S_IDLE: if (start) begin
        nxt = S_LEAD; ctl.loadMsg = 1'b1; ctl.armSeg = 1'b1;
      end
      S_LEAD: if (segEnd) begin
        ctl.armSeg = 1'b1;
        if (isMsg && hasBytes) begin nxt = S_BHI; ctl.segKind = SEG_BIT_HI; end
        else                         nxt = S_TAIL;
      end
      S_BHI: if (segEnd) begin
        nxt = S_BLO; ctl.armSeg = 1'b1; ctl.segKind = SEG_BIT_LO; ctl.stepBit = 1'b1;
      end
      S_BLO: if (segEnd) begin
        ctl.armSeg = 1'b1;
        if (bitWrap && allSent) begin
          if (modeQ == MODE_DATA) begin nxt = S_GUARD; ctl.segKind = SEG_GUARD; end
          else                          nxt = S_TAIL;
        end else begin
          nxt = S_BHI; ctl.segKind = SEG_BIT_HI;
        end
      end
      S_TAIL: if (segEnd) begin
        if (modeQ == MODE_TONE) begin
          nxt = S_TONE; ctl.armSeg = 1'b1; ctl.segKind = SEG_BURST;
        end else if (modeQ == MODE_DATA) begin
          nxt = S_BHI; ctl.armSeg = 1'b1; ctl.segKind = SEG_BIT_HI;
        end else begin
          nxt = S_IDLE; fin = 1'b1;
        end
      end
      S_TONE: if (segEnd) begin
        nxt = S_GUARD; ctl.armSeg = 1'b1; ctl.segKind = SEG_GUARD;
      end
      S_GUARD: if (segEnd) begin
        nxt = S_IDLE; fin = 1'b1;
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      modeQ <= MODE_MSG;
      done  <= 1'b0;
    end else begin
      state <= nxt;
      done  <= fin;
      if (state == S_IDLE && start) modeQ <= mode;
    end
  end

  assign env  = (state == S_BHI) || (state == S_TONE);
  assign busy = (state != S_IDLE);

  // ---------------- assertions ----------------
  a_r1_env_low_idle: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !env);

  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r10_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

endmodule

// File: rtl/tone_envelope_tx.sv
module tone_envelope_tx
  import tone_env_pkg::*;
#(
  parameter int CLK_PER_US  = 100,
  parameter int MAX_BYTES   = 8,
  parameter int T_SHORT_US  = 500,
  parameter int T_LONG_US   = 1000,
  parameter int T_GAP_US    = 16000,
  parameter int T_BURST_US  = 12500,
  parameter int T_GUARD_US  = 20000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ldValid,
  input  logic [7:0] ldData,
  input  logic       start,
  input  logic [1:0] mode,
  output logic       env,
  output logic       busy,
  output logic       done
);

  ctlS  ctl;
  modeE modeIn;
  logic segEnd, curBit, bitWrap, allSent, hasBytes;

  assign modeIn = modeE'(mode);

  tone_env_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start), .mode(modeIn),
    .segEnd(segEnd), .bitWrap(bitWrap), .allSent(allSent), .hasBytes(hasBytes),
    .ctl(ctl), .env(env), .busy(busy), .done(done)
  );

  tone_env_datapath #(
    .CLK_PER_US(CLK_PER_US), .MAX_BYTES(MAX_BYTES),
    .T_SHORT_US(T_SHORT_US), .T_LONG_US(T_LONG_US), .T_GAP_US(T_GAP_US),
    .T_BURST_US(T_BURST_US), .T_GUARD_US(T_GUARD_US)
  ) u_dp (
    .clk(clk), .rst(rst), .busy(busy), .ctl(ctl), .mode(modeIn),
    .ldValid(ldValid), .ldData(ldData),
    .segEnd(segEnd), .curBit(curBit), .bitWrap(bitWrap),
    .allSent(allSent), .hasBytes(hasBytes)
  );

endmodule

// File: tb/tone_envelope_tx_bench.sv
module tone_envelope_tx_bench;

  localparam int K   = 3;
  localparam int NB  = 4;
  localparam int TS  = 2;
  localparam int TL  = 4;
  localparam int TG  = 10;
  localparam int TB  = 8;
  localparam int TGD = 12;
  localparam int RUN_LIMIT = 5000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ldValid = 1'b0;
  logic [7:0] ldData = 8'h00;
  logic       start = 1'b0;
  logic [1:0] mode = 2'd0;
  logic       env, busy, done;

  tone_envelope_tx #(
    .CLK_PER_US(K), .MAX_BYTES(NB), .T_SHORT_US(TS), .T_LONG_US(TL),
    .T_GAP_US(TG), .T_BURST_US(TB), .T_GUARD_US(TGD)
  ) u_tone_envelope_tx (
    .clk(clk), .rst(rst), .ldValid(ldValid), .ldData(ldData),
    .start(start), .mode(mode), .env(env), .busy(busy), .done(done)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  int expLvl[256], expLen[256], expN;
  int gotLvl[256], gotLen[256], gotN;
  logic [7:0] txBytes[8];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog actual %0d expected below %0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // expected waveform as merged runs of (level, cycles)
  task automatic addSeg(input int lvl, input int ticks);
    if (expN > 0 && expLvl[expN-1] == lvl) expLen[expN-1] += ticks * K;
    else begin
      expLvl[expN] = lvl; expLen[expN] = ticks * K; expN++;
    end
  endtask

  task automatic addBit(input bit b);
    addSeg(1, b ? TS : TL);
    addSeg(0, b ? TL : TS);
  endtask

  task automatic addByte(input logic [7:0] v);
    bit p = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      p = p ^ v[i];
      addBit(v[i]);
    end
    addBit(p);
  endtask

  task automatic buildExp(input int md, input int nb);
    expN = 0;
    addSeg(0, TG);
    if (md == 0 || md == 3)
      for (int i = 0; i < nb && i < NB; i++) addByte(txBytes[i]);
    addSeg(0, TG);
    if (md == 1) begin addSeg(1, TB); addSeg(0, TGD); end
    if (md == 2) begin addByte(8'hFF); addSeg(0, TGD); end
  endtask

  task automatic loadBytes(input int nb);
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      ldValid = 1'b1;
      ldData  = txBytes[i];
    end
    @(negedge clk);
    ldValid = 1'b0;
  endtask

  task automatic runTx(input int md, input int nb, input bit interfere, input string tag);
    int n = 0;
    bit sawDone = 1'b0;
    bit badBusy = 1'b0;
    int k;
    buildExp(md, nb);
    gotN = 0;
    @(negedge clk);
    start = 1'b1;
    mode  = 2'(md);
    @(negedge clk);
    start = 1'b0;
    while (n < RUN_LIMIT) begin
      if (done) begin sawDone = 1'b1; break; end
      if (!busy) badBusy = 1'b1;
      if (gotN > 0 && gotLvl[gotN-1] == int'(env)) gotLen[gotN-1]++;
      else if (gotN < 256) begin gotLvl[gotN] = int'(env); gotLen[gotN] = 1; gotN++; end
      n++;
      if (interfere && n == 7) begin
        start = 1'b1; ldValid = 1'b1; ldData = 8'h3C; mode = 2'd1;
      end
      if (interfere && n == 8) begin
        start = 1'b0; ldValid = 1'b0;
      end
      @(negedge clk);
    end
    check(sawDone, "R10", "done seen", int'(sawDone), 1);
    check(!badBusy, "R10", "busy through frame", int'(badBusy), 0);
    check(busy == 1'b0, "R10", "busy in done cycle", int'(busy), 0);
    k = 0;
    while (k < gotN && k < expN && gotLvl[k] == expLvl[k] && gotLen[k] == expLen[k]) k++;
    check(gotN == expN, tag, "run count", gotN, expN);
    if (k < gotN && k < expN)
      check(1'b0, tag, "run length", gotLen[k], expLen[k]);
    else
      check(1'b1, tag, "run length", 0, 0);
    @(negedge clk);
    check(done == 1'b0, "R10", "done width", int'(done), 0);
    if (interfere) begin
      for (int i = 0; i < 3; i++) begin
        check(busy == 1'b0 && env == 1'b0, "R9", "no restart after busy start", int'(busy), 0);
        @(negedge clk);
      end
    end
  endtask

  initial begin
    int md, nb;
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(negedge clk);
    check(env == 1'b0, "R1", "env in reset", int'(env), 0);
    check(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
    check(done == 1'b0, "R1", "done in reset", int'(done), 0);
    rst = 1'b0;
    @(negedge clk);
    check(env == 1'b0 && busy == 1'b0, "R1", "idle after reset", int'(busy), 0);

    // R2 R3 R11: single byte with mixed bits, exact cycle lengths
    txBytes[0] = 8'hA5;
    loadBytes(1);
    runTx(0, 1, 1'b0, "R2 R3 R11");

    // R4: several bytes in load order, all-zero and all-one data
    txBytes[0] = 8'h00; txBytes[1] = 8'hFF; txBytes[2] = 8'h81;
    loadBytes(3);
    runTx(0, 3, 1'b0, "R4");

    // R8: empty message (store was cleared by previous start)
    runTx(0, 0, 1'b0, "R8");

    // R5: tone burst ignores stored bytes
    txBytes[0] = 8'h12; txBytes[1] = 8'h34;
    loadBytes(2);
    runTx(1, 0, 1'b0, "R5");

    // R6: modulated burst ignores stored bytes
    txBytes[0] = 8'h55;
    loadBytes(1);
    runTx(2, 0, 1'b0, "R6");

    // R7: mode 3 acts as message
    txBytes[0] = 8'hC3; txBytes[1] = 8'h0F;
    loadBytes(2);
    runTx(3, 2, 1'b0, "R7");

    // R8: overfill, extra bytes dropped
    for (int i = 0; i < 6; i++) txBytes[i] = 8'(8'h10 + i * 7);
    loadBytes(6);
    runTx(0, 6, 1'b0, "R8");

    // R9: start and load during a frame are ignored
    txBytes[0] = 8'h96;
    loadBytes(1);
    runTx(0, 1, 1'b1, "R9");
    runTx(0, 0, 1'b0, "R9");

    // random frames
    for (int t = 0; t < 12; t++) begin
      md = int'($urandom % 4);
      nb = int'($urandom % (NB + 2));
      for (int i = 0; i < 8; i++) txBytes[i] = 8'($urandom);
      loadBytes(nb);
      case (md)
        0: runTx(md, nb, 1'b0, "R4");
        1: runTx(md, nb, 1'b0, "R5");
        2: runTx(md, nb, 1'b0, "R6");
        default: runTx(md, nb, 1'b0, "R7");
      endcase
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule